// File: doc/BRIEF.md
# Width-Switching Accumulator and Index Register File

This block holds the programmer-visible data registers of an 8/16-bit processor core. The accumulator is a 16-bit register with a low byte and a high byte. When the accumulator runs at byte width, the high byte is kept hidden and unchanged. There are two index registers, a stack pointer and a direct-page base register. Writes and reads follow the current width flags. An accumulator-width flag selects byte or word access to the accumulator. An index-width flag does the same for both index registers. An emulation input locks both widths to byte size and pins the stack to page one.

The surrounding core drives a register select, write data and a write strobe. It also gives a small operation code for the accumulator byte swap and for the four word transfers between the accumulator and the direct-page or stack registers. The core must pulse a truncate input whenever the index width drops to byte size. This pulse discards the upper index bytes. The block presents a width-gated read port and a continuous view of every register.

Top module: `acc_index_regs`

## Requirements
- R1: With the effective accumulator width at byte (`m_flag`=1 or `emu`=1), an accumulator write changes only bits 7:0. Bits 15:8 keep their value. A read through `rd_data` returns `{8'h00, low byte}`.
- R2: With `m_flag`=0 and `emu`=0, an accumulator write stores all 16 bits, and `rd_data` returns all 16 bits.
- R3: Operation code 1 (swap) exchanges the accumulator's low and high bytes in every mode.
- R4: While the effective index width is byte (`x_flag`=1 or `emu`=1), bits 15:8 of `x_q`, `y_q` and the X/Y reads are 0x00. A cycle with `idx_trunc`=1 clears the stored upper bytes of X and Y, so they stay 0x00 after the width returns to word.
- R5: Operation codes 2 (acc→DP), 3 (DP→acc), 4 (acc→SP) and 5 (SP→acc) move all 16 bits whatever `m_flag` is. The only exception is the SP high byte in emulation mode (R7).
- R6: When `emu` falls, the accumulator high byte is unchanged and the index upper bytes read 0x00.
- R7: While `emu`=1, the stack pointer high byte is 0x01. SP writes and acc→SP transfers change only its low byte.
- R8: After reset, accumulator, X, Y and DP are 0x0000 and SP is 0x01FF.
- R9: An X or Y write with the effective index width at byte stores only the low byte of `wr_data`.
- R10: When `op` is non-zero, `wr_en` is ignored for that cycle, and only the operation takes effect.
- R11: When `idx_trunc` and an X/Y write fall in the same cycle, the low byte is written and the upper byte ends 0x00.
- R12: Register select codes are 0 accumulator, 1 X, 2 Y, 3 SP and 4 DP. The DP register is always written and read at 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 3 | Register select for write and read |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| op | input | 3 | 0 none, 1 swap, 2 acc→DP, 3 DP→acc, 4 acc→SP, 5 SP→acc |
| m_flag | input | 1 | Accumulator width flag, 1 = byte |
| x_flag | input | 1 | Index width flag, 1 = byte |
| emu | input | 1 | Emulation mode |
| idx_trunc | input | 1 | Pulse that clears the index upper bytes |
| rd_data | output | 16 | Width-gated read of the selected register |
| acc_q | output | 16 | Full accumulator, high byte included |
| x_q | output | 16 | X view, upper byte zero at byte width |
| y_q | output | 16 | Y view, upper byte zero at byte width |
| sp_q | output | 16 | Stack pointer |
| dp_q | output | 16 | Direct-page register |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a register write and an operation code. The second pair is an index truncate pulse and an index write. The bench drives a swap together with an accumulator write, and an acc→DP transfer together with a DP write. It expects the operation's result and no trace of the write data. It also pulses truncate while writing a full word to X at word width. It expects the new low byte under a zero upper byte.

// File: rtl/acc_index_regs.sv
module acc_index_regs #(
  parameter logic [15:0] SP_RESET = 16'h01FF,
  parameter logic [7:0]  SP_PAGE  = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  sel,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic [2:0]  op,
  input  logic        m_flag,
  input  logic        x_flag,
  input  logic        emu,
  input  logic        idx_trunc,
  output logic [15:0] rd_data,
  output logic [15:0] acc_q,
  output logic [15:0] x_q,
  output logic [15:0] y_q,
  output logic [15:0] sp_q,
  output logic [15:0] dp_q
);
  localparam logic [2:0] SEL_ACC = 3'd0, SEL_X = 3'd1, SEL_Y = 3'd2, SEL_SP = 3'd3, SEL_DP = 3'd4;
  localparam logic [2:0] OP_NONE = 3'd0, OP_SWAP = 3'd1, OP_C2DP = 3'd2,
                         OP_DP2C = 3'd3, OP_C2SP = 3'd4, OP_SP2C = 3'd5;

  logic [7:0]  a_lo, b_hi, xl, xh, yl, yh;
  logic [15:0] sp, dp;

  wire m_byte = m_flag | emu;
  wire x_byte = x_flag | emu;
  wire wr_ok  = wr_en && (op == OP_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_lo <= 8'h00; b_hi <= 8'h00;
      xl <= 8'h00; xh <= 8'h00;
      yl <= 8'h00; yh <= 8'h00;
      sp <= SP_RESET; dp <= 16'h0000;
    end else begin
      if (wr_ok) begin
        case (sel)
          SEL_ACC: begin
            a_lo <= wr_data[7:0];
            if (!m_byte) b_hi <= wr_data[15:8];
          end
          SEL_X: begin
            xl <= wr_data[7:0];
            if (!x_byte) xh <= wr_data[15:8];
          end
          SEL_Y: begin
            yl <= wr_data[7:0];
            if (!x_byte) yh <= wr_data[15:8];
          end
          SEL_SP: begin
            sp[7:0] <= wr_data[7:0];
            if (!emu) sp[15:8] <= wr_data[15:8];
          end
          SEL_DP: dp <= wr_data;
          default: ;
        endcase
      end
      case (op)
        OP_SWAP: begin a_lo <= b_hi; b_hi <= a_lo; end
        OP_C2DP: dp <= {b_hi, a_lo};
        OP_DP2C: {b_hi, a_lo} <= dp;
        OP_C2SP: sp <= {(emu ? SP_PAGE : b_hi), a_lo};
        OP_SP2C: {b_hi, a_lo} <= sp;
        default: ;
      endcase
      if (idx_trunc || emu) begin
        xh <= 8'h00;
        yh <= 8'h00;
      end
      if (emu) sp[15:8] <= SP_PAGE;
    end
  end

  assign acc_q = {b_hi, a_lo};
  assign x_q   = {(x_byte ? 8'h00 : xh), xl};
  assign y_q   = {(x_byte ? 8'h00 : yh), yl};
  assign sp_q  = sp;
  assign dp_q  = dp;

  always_comb begin
    case (sel)
      SEL_ACC: rd_data = m_byte ? {8'h00, a_lo} : {b_hi, a_lo};
      SEL_X:   rd_data = x_q;
      SEL_Y:   rd_data = y_q;
      SEL_SP:  rd_data = sp;
      SEL_DP:  rd_data = dp;
      default: rd_data = 16'h0000;
    endcase
  end

  assert_b_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_NONE && sel == SEL_ACC && m_byte) |=> (b_hi == $past(b_hi)));

  assert_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SWAP) |=> (acc_q == {$past(a_lo), $past(b_hi)}));

  assert_trunc_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_trunc || emu) |=> (xh == 8'h00 && yh == 8'h00));

  assert_xfer_dp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_C2DP) |=> (dp == $past(acc_q)));

  assert_xfer_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SP2C) |=> (acc_q == $past(sp)));

  assert_sp_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    emu |=> (sp[15:8] == SP_PAGE));

  assert_write_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DP && op == OP_SWAP) |=> $stable(dp));
endmodule

// File: tb/acc_index_regs_test.sv
module acc_index_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  sel;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [2:0]  op;
  logic        m_flag, x_flag, emu, idx_trunc;
  logic [15:0] rd_data, acc_q, x_q, y_q, sp_q, dp_q;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  acc_index_regs uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .op(op), .m_flag(m_flag), .x_flag(x_flag), .emu(emu), .idx_trunc(idx_trunc),
    .rd_data(rd_data), .acc_q(acc_q), .x_q(x_q), .y_q(y_q), .sp_q(sp_q), .dp_q(dp_q)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] s, input logic w, input logic [15:0] d,
                      input logic [2:0] o, input logic t);
    sel = s; wr_en = w; wr_data = d; op = o; idx_trunc = t;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; op = 3'd0; idx_trunc = 1'b0;
  endtask

  task automatic test_reset;
    check("R8", "acc", acc_q, 16'h0000);
    check("R8", "x", x_q, 16'h0000);
    check("R8", "y", y_q, 16'h0000);
    check("R8", "sp", sp_q, 16'h01FF);
    check("R8", "dp", dp_q, 16'h0000);
  endtask

  task automatic test_emulation;
    step(3'd0, 1'b1, 16'h1234, 3'd0, 1'b0);
    check("R1", "emu acc byte write", acc_q, 16'h0034);
    step(3'd0, 1'b0, 16'h0000, 3'd1, 1'b0);
    check("R3", "emu swap", acc_q, 16'h3400);
    step(3'd3, 1'b1, 16'h3344, 3'd0, 1'b0);
    check("R7", "emu sp write", sp_q, 16'h0144);
    step(3'd1, 1'b1, 16'hABCD, 3'd0, 1'b0);
    check("R9", "emu x write", x_q, 16'h00CD);
    step(3'd0, 1'b0, 16'h0000, 3'd4, 1'b0);
    check("R7", "emu acc->sp", sp_q, 16'h0100);
  endtask

  task automatic test_enter_native;
    emu = 1'b0;
    step(3'd1, 1'b0, 16'h0000, 3'd0, 1'b0);
    x_flag = 1'b0;
    #1;
    check("R6", "b kept", acc_q, 16'h3400);
    check("R6", "x upper zero", x_q, 16'h00CD);
    x_flag = 1'b1;
  endtask

  task automatic test_acc_widths;
    m_flag = 1'b0;
    step(3'd0, 1'b1, 16'h1234, 3'd0, 1'b0);
    check("R2", "word acc", acc_q, 16'h1234);
    check("R2", "word read", rd_data, 16'h1234);
    m_flag = 1'b1;
    step(3'd0, 1'b1, 16'hFFAB, 3'd0, 1'b0);
    check("R1", "byte write keeps B", acc_q, 16'h12AB);
    check("R1", "byte read", rd_data, 16'h00AB);
    step(3'd0, 1'b0, 16'h0000, 3'd1, 1'b0);
    check("R3", "native swap", acc_q, 16'hAB12);
  endtask

  task automatic test_transfers;
    step(3'd4, 1'b0, 16'h0000, 3'd2, 1'b0);
    check("R5", "acc->dp m=1", dp_q, 16'hAB12);
    step(3'd0, 1'b1, 16'h0077, 3'd0, 1'b0);
    step(3'd3, 1'b0, 16'h0000, 3'd4, 1'b0);
    check("R5", "acc->sp m=1", sp_q, 16'hAB77);
    step(3'd4, 1'b1, 16'h5A00, 3'd0, 1'b0);
    check("R12", "dp word read", rd_data, 16'h5A00);
    step(3'd0, 1'b0, 16'h0000, 3'd3, 1'b0);
    check("R5", "dp->acc m=1", acc_q, 16'h5A00);
    step(3'd0, 1'b0, 16'h0000, 3'd5, 1'b0);
    check("R5", "sp->acc m=1", acc_q, 16'hAB77);
  endtask

  task automatic test_index;
    x_flag = 1'b0;
    step(3'd1, 1'b1, 16'h5678, 3'd0, 1'b0);
    check("R12", "x word", x_q, 16'h5678);
    step(3'd2, 1'b1, 16'h9ABC, 3'd0, 1'b0);
    check("R12", "y word read", rd_data, 16'h9ABC);
    x_flag = 1'b1;
    #1;
    check("R4", "x view byte", x_q, 16'h0078);
    step(3'd1, 1'b0, 16'h0000, 3'd0, 1'b1);
    x_flag = 1'b0;
    #1;
    check("R4", "x after truncate", x_q, 16'h0078);
    check("R4", "y after truncate", y_q, 16'h00BC);
    x_flag = 1'b1;
    step(3'd2, 1'b1, 16'hFF99, 3'd0, 1'b0);
    x_flag = 1'b0;
    #1;
    check("R9", "y byte write", y_q, 16'h0099);
  endtask

  task automatic test_collisions;
    step(3'd0, 1'b1, 16'h0000, 3'd1, 1'b0);
    check("R10", "swap beats write", acc_q, 16'h77AB);
    step(3'd4, 1'b1, 16'h1111, 3'd2, 1'b0);
    check("R10", "transfer beats write", dp_q, 16'h77AB);
    step(3'd1, 1'b1, 16'h4321, 3'd0, 1'b1);
    check("R11", "truncate with write", x_q, 16'h0021);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel = 3'd0; wr_en = 1'b0; wr_data = 16'h0; op = 3'd0;
    m_flag = 1'b1; x_flag = 1'b1; emu = 1'b1; idx_trunc = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset;
    test_emulation;
    test_enter_native;
    test_acc_widths;
    test_transfers;
    test_index;
    test_collisions;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule